// File: doc/BRIEF.md
# Branch History Packet Accumulator

This block collects the history field for branch trace messages that use the history format. Between two indirect-branch messages, every taken direct branch adds a 1 and every predicated instruction that is skipped adds a 0. Each new bit enters a left-shifting register at bit 0. The register always starts out holding a lone 1. That bit is a stop marker: it travels upward as events arrive, so a decoder can see where the recorded bits begin. The marker is sent with the packet but is not itself a recorded event.

A flush strobe marks an indirect-branch message. On a flush the block emits the current register as a packet and restarts from the lone 1. If the register fills, meaning the marker reaches the top bit, the block emits a history-full packet on its own and restarts. Each packet carries the word, its length counted up to and including the marker, and a flag that separates history-full packets from flush packets. Assembling the rest of the message and sending it are left to the consumer.

Packets leave through a one-entry valid/ready output. A packet stays on the outputs, unchanged, until the consumer raises `pkt_ready` while `pkt_valid` is high. While a packet is held and `pkt_ready` is low, the block is stalled: event and flush strobes are ignored and the history register is frozen. A consumer that wants a complete trace must therefore keep `pkt_ready` high.

Top module: `branch_hist_acc`

## Requirements
- R1: After reset, `pkt_valid` is 0 and the history register holds the lone stop marker. A first flush therefore yields word 1, length 1, `pkt_full` 0.
- R2: Strobes are acted on only while both `trace_en` and `hist_mode` are 1. Otherwise events and flushes are ignored and the history is kept unchanged.
- R3: An event shifts the register left by one and places the new bit at bit 0. `br_taken` enters 1 and `pred_skip` enters 0. If both strobes are high in the same cycle, a single 1 is recorded.
- R4: A flush emits the register as it stood before that edge, with `pkt_full` 0. After n recorded events the word is 2^n plus the n bits, with the oldest bit highest. The register then re-arms to 1.
- R5: `pkt_len` equals the bit index of the highest 1 in `pkt_word` plus one. It counts the stop marker, so it ranges from 1 to 32.
- R6: The event that would move the marker into bit 31 emits that 32-bit word itself, with `pkt_full` 1 and length 32. The register re-arms to 1, and no packet is produced for the 30 events before it.
- R7: When a flush and an event occur in the same cycle, the flush packet excludes that event. The event becomes the first bit of the next packet.
- R8: A packet appears on the outputs in the cycle after the edge that produced it. It stays valid and stable while `pkt_ready` is low, and `pkt_valid` falls after an edge with `pkt_ready` high unless a new packet is loaded on that edge.
- R9: While `pkt_valid` is 1 and `pkt_ready` is 0, event and flush strobes are ignored and the history register is frozen.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trace_en | input | 1 | Program trace enable |
| hist_mode | input | 1 | Selects the history message format |
| br_taken | input | 1 | A taken direct branch this cycle |
| pred_skip | input | 1 | A predicated instruction not executed this cycle |
| flush | input | 1 | An indirect-branch message is being produced |
| pkt_ready | input | 1 | Consumer accepts the packet |
| pkt_valid | output | 1 | A packet is present |
| pkt_word | output | 32 | History word including the stop marker |
| pkt_len | output | 6 | Valid length in bits, counting the marker |
| pkt_full | output | 1 | Overflow: packet was emitted because the register filled |

## Verification
The bench sweeps every history depth from 0 to 30 events under two bit patterns. For each depth it computes the expected word and length arithmetically, so an off-by-one in the marker position or in the length shows up at a specific depth. It drives exactly 31 events to confirm that the history-full packet appears on the 31st event and not a cycle early or late. It also checks that the register re-arms to 1 afterwards; a design that kept the saturated word would emit a long word on the next flush.

The bench combines a flush and an event in one cycle. A design that dropped that event, or put it into the outgoing packet, would produce the wrong word on one of the two following packets. The bench also holds `pkt_ready` low while sending strobes. A design that kept recording during a stall would change the held word, or would report events in the packet after the stall.

// File: rtl/bh_pkg.sv
package bh_pkg;
  localparam int unsigned HIST_W_DEF = 32;

  typedef enum logic {
    PKT_FLUSH = 1'b0,
    PKT_FULL  = 1'b1
  } pkt_kind_e;
endpackage

// File: rtl/bh_msb_len.sv
module bh_msb_len #(
  parameter int unsigned W  = 32,
  parameter int unsigned LW = $clog2(W + 1)
) (
  input  logic [W-1:0]  vec,
  output logic [LW-1:0] len
);
  // Position of the highest set bit plus one; zero for an all-zero vector.
  always_comb begin
    len = '0;
    for (int i = 0; i < W; i++) begin
      if (vec[i]) len = LW'(i + 1);
    end
  end
endmodule

// File: rtl/bh_shift_core.sv
module bh_shift_core
  import bh_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         act,
  input  logic         ev_taken,
  input  logic         ev_skip,
  input  logic         flush,
  output logic         emit,
  output logic [W-1:0] emit_word,
  output pkt_kind_e    emit_kind
);
  localparam logic [W-1:0] STOP_ONLY = W'(1);

  logic [W-1:0] hist_q, hist_d, shifted, rearm;
  logic         ev, ev_bit;

  always_comb begin
    ev        = ev_taken | ev_skip;
    ev_bit    = ev_taken;
    shifted   = {hist_q[W-2:0], ev_bit};
    // A same-cycle event lands in the freshly re-armed register.
    rearm     = ev ? W'({1'b1, ev_bit}) : STOP_ONLY;
    hist_d    = hist_q;
    emit      = 1'b0;
    emit_word = hist_q;
    emit_kind = PKT_FLUSH;
    if (act && flush) begin
      emit   = 1'b1;
      hist_d = rearm;
    end else if (act && ev) begin
      if (shifted[W-1]) begin
        emit      = 1'b1;
        emit_word = shifted;
        emit_kind = PKT_FULL;
        hist_d    = STOP_ONLY;
      end else begin
        hist_d = shifted;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist_q <= STOP_ONLY;
    else        hist_q <= hist_d;
  end

  AST_REARM_AFTER_EMIT: assert property (@(posedge clk) disable iff (!rst_n)
    emit |=> (hist_q < W'(4))); // R4

  AST_FROZEN_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !act |=> $stable(hist_q)); // R2

  AST_TOP_NEVER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !hist_q[W-1]); // R6

  AST_MARKER_PRESENT: assert property (@(posedge clk) disable iff (!rst_n)
    hist_q != '0); // R1
endmodule

// File: rtl/bh_out_slot.sv
module bh_out_slot
  import bh_pkg::*;
#(
  parameter int unsigned W  = 32,
  parameter int unsigned LW = $clog2(W + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [W-1:0]  in_word,
  input  logic [LW-1:0] in_len,
  input  pkt_kind_e     in_kind,
  input  logic          ready,
  output logic          valid,
  output logic [W-1:0]  word,
  output logic [LW-1:0] len,
  output logic          full,
  output logic          stall
);
  assign stall = valid & ~ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      word  <= '0;
      len   <= '0;
      full  <= 1'b0;
    end else if (load) begin
      valid <= 1'b1;
      word  <= in_word;
      len   <= in_len;
      full  <= (in_kind == PKT_FULL);
    end else if (ready) begin
      valid <= 1'b0;
    end
  end

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready) |=> (valid && $stable(word) && $stable(len) && $stable(full))); // R8

  AST_NO_LOAD_IN_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> !load); // R9

  AST_FULL_AT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && full) |-> (word[W-1] && len == LW'(W))); // R6

  AST_FLUSH_BELOW_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !full) |-> !word[W-1]); // R4

  AST_LEN_MARKS_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> (len != '0 && word[len - LW'(1)])); // R5
endmodule

// File: rtl/branch_hist_acc.sv
module branch_hist_acc
  import bh_pkg::*;
#(
  parameter int unsigned HIST_W = HIST_W_DEF,
  localparam int unsigned LEN_W = $clog2(HIST_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trace_en,
  input  logic              hist_mode,
  input  logic              br_taken,
  input  logic              pred_skip,
  input  logic              flush,
  input  logic              pkt_ready,
  output logic              pkt_valid,
  output logic [HIST_W-1:0] pkt_word,
  output logic [LEN_W-1:0]  pkt_len,
  output logic              pkt_full
);
  logic              stall, act, emit;
  logic [HIST_W-1:0] emit_word;
  logic [LEN_W-1:0]  emit_len;
  pkt_kind_e         emit_kind;

  // Recording runs only in history mode with trace on and the output slot free.
  assign act = trace_en & hist_mode & ~stall;

  bh_shift_core #(.W(HIST_W)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .act       (act),
    .ev_taken  (br_taken),
    .ev_skip   (pred_skip),
    .flush     (flush),
    .emit      (emit),
    .emit_word (emit_word),
    .emit_kind (emit_kind)
  );

  bh_msb_len #(.W(HIST_W), .LW(LEN_W)) u_len (
    .vec (emit_word),
    .len (emit_len)
  );

  bh_out_slot #(.W(HIST_W), .LW(LEN_W)) u_slot (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (emit),
    .in_word (emit_word),
    .in_len  (emit_len),
    .in_kind (emit_kind),
    .ready   (pkt_ready),
    .valid   (pkt_valid),
    .word    (pkt_word),
    .len     (pkt_len),
    .full    (pkt_full),
    .stall   (stall)
  );

  AST_MODE_GATES_EMIT: assert property (@(posedge clk) disable iff (!rst_n)
    !(trace_en && hist_mode) |=> !pkt_valid || $stable(pkt_word)); // R2
endmodule

// File: tb/tb_branch_hist_acc.sv
`timescale 1ns/1ps
module tb_branch_hist_acc;
  logic        clk = 1'b0;
  logic        rst_n, trace_en, hist_mode, br_taken, pred_skip, flush, pkt_ready;
  logic        pkt_valid, pkt_full;
  logic [31:0] pkt_word;
  logic [5:0]  pkt_len;
  int tests = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  branch_hist_acc dut (
    .clk(clk), .rst_n(rst_n), .trace_en(trace_en), .hist_mode(hist_mode),
    .br_taken(br_taken), .pred_skip(pred_skip), .flush(flush),
    .pkt_ready(pkt_ready), .pkt_valid(pkt_valid), .pkt_word(pkt_word),
    .pkt_len(pkt_len), .pkt_full(pkt_full)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic ev(input logic b);
    br_taken  = b;
    pred_skip = ~b;
    step();
    br_taken  = 1'b0;
    pred_skip = 1'b0;
  endtask

  task automatic do_flush(input logic with_taken);
    flush    = 1'b1;
    br_taken = with_taken;
    step();
    flush    = 1'b0;
    br_taken = 1'b0;
  endtask

  task automatic expect_pkt(input string tag, input logic [31:0] w, input int len, input logic full);
    chk({tag, " valid"}, 64'(pkt_valid), 64'd1);
    chk({tag, " word"},  64'(pkt_word),  64'(w));
    chk({tag, " len"},   64'(pkt_len),   64'(len));
    chk({tag, " full"},  64'(pkt_full),  64'(full));
  endtask

  function automatic logic [31:0] pat(input int n, input int s);
    logic [31:0] x;
    logic [63:0] m;
    m = (64'd1 << n) - 64'd1;
    x = 32'h9E3779B9 * 32'(n + 3 + s * 11);
    if (s != 0) x = x ^ 32'hA5A5_C3C3;
    return x & m[31:0];
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    rst_n = 1'b0; trace_en = 1'b1; hist_mode = 1'b1;
    br_taken = 1'b0; pred_skip = 1'b0; flush = 1'b0; pkt_ready = 1'b1;
    step(); step();
    chk("R1 reset valid", 64'(pkt_valid), 64'd0);
    rst_n = 1'b1;
    step();
    chk("R1 idle after reset", 64'(pkt_valid), 64'd0);
    do_flush(1'b0);
    expect_pkt("R1 first flush", 32'd1, 1, 1'b0);
    step();
    chk("R8 valid drops after accept", 64'(pkt_valid), 64'd0);

    // R3 R4 R5: sweep of every depth below saturation, two patterns
    for (int s = 0; s < 2; s++) begin
      for (int n = 0; n <= 30; n++) begin
        v = pat(n, s);
        for (int i = n - 1; i >= 0; i--) ev(v[i]);
        if (n > 0) chk("R3 no packet before flush", 64'(pkt_valid), 64'd0);
        do_flush(1'b0);
        expect_pkt("R4 R5 sweep", 32'(64'd1 << n) | v, n + 1, 1'b0);
      end
    end

    // R6: saturation on the 31st event
    v = pat(31, 1);
    for (int i = 30; i >= 1; i--) ev(v[i]);
    chk("R6 no packet after 30 events", 64'(pkt_valid), 64'd0);
    ev(v[0]);
    expect_pkt("R6 history-full", 32'h8000_0000 | v, 32, 1'b1);
    do_flush(1'b0);
    expect_pkt("R6 re-armed", 32'd1, 1, 1'b0);

    // R7: flush with same-cycle event
    ev(1'b1); ev(1'b0);
    do_flush(1'b1);
    expect_pkt("R7 flush excludes event", 32'b110, 3, 1'b0);
    do_flush(1'b0);
    expect_pkt("R7 event carried over", 32'b11, 2, 1'b0);

    // R3: both strobes record a single 1
    br_taken = 1'b1; pred_skip = 1'b1;
    step();
    br_taken = 1'b0; pred_skip = 1'b0;
    do_flush(1'b0);
    expect_pkt("R3 both strobes", 32'b11, 2, 1'b0);

    // R2: mode and enable gating
    hist_mode = 1'b0;
    ev(1'b1);
    do_flush(1'b0);
    chk("R2 hist_mode off no packet", 64'(pkt_valid), 64'd0);
    hist_mode = 1'b1; trace_en = 1'b0;
    ev(1'b0);
    do_flush(1'b0);
    chk("R2 trace_en off no packet", 64'(pkt_valid), 64'd0);
    trace_en = 1'b1;
    do_flush(1'b0);
    expect_pkt("R2 nothing recorded", 32'd1, 1, 1'b0);

    // R8 R9: back-pressure
    ev(1'b1);
    pkt_ready = 1'b0;
    do_flush(1'b0);
    expect_pkt("R8 held packet", 32'b11, 2, 1'b0);
    ev(1'b1);
    expect_pkt("R9 stall ignores event", 32'b11, 2, 1'b0);
    do_flush(1'b0);
    expect_pkt("R9 stall ignores flush", 32'b11, 2, 1'b0);
    ev(1'b0);
    expect_pkt("R8 stable under stall", 32'b11, 2, 1'b0);
    pkt_ready = 1'b1;
    step();
    chk("R8 accepted", 64'(pkt_valid), 64'd0);
    do_flush(1'b0);
    expect_pkt("R9 history frozen during stall", 32'd1, 1, 1'b0);
    step();

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule